// File: doc/BRIEF.md
# Ternary H-bridge switch decoder

This block sits between a PWM modulator and the gate drivers of a two-channel class-D output stage. For each channel it takes a pair of logic-level PWM inputs, A and B, and produces enables for the four switches of one H-bridge. Leg A is formed by Q1 (high side) and Q3 (low side). Leg B is formed by Q2 (high side) and Q4 (low side). The pair 00 selects a damped state in which both low sides conduct. The pairs 01 and 10 drive the load in either polarity. The pair 11 is an unused code: the block decodes it and also flags it.

A parallel-mode input ties leg B to the A input, so that both legs of a channel switch together. Each leg switches through a programmable dead time, counted in clock cycles, during which neither of its switches conducts. Every on-period of a switch is held for at least a programmable minimum width. Three global controls force every switch off: an active-low high-impedance request, an active-low power-up input and an active-high protection kill. The kill overrides everything else.

Top module: `hb_switch_dec`

## Requirements
- R1: With enables active and parallel mode off, a steady input pair A=0,B=0 turns on Q3 and Q4 only. The per-channel output nibble is {Q4,Q3,Q2,Q1}, so this reads 4'b1100. Channel c occupies sw_o[4c+3:4c].
- R2: A steady A=1,B=0 turns on Q1 and Q4 only (4'b1001). A steady A=0,B=1 turns on Q2 and Q3 only (4'b0110).
- R3: A steady A=1,B=1 turns on Q1 and Q2 (4'b0011). When parallel mode is off, bad_code_o[c] is 1 after the next clock edge while that code is present, and 0 otherwise.
- R4: With par_mode_i high, input B is ignored: both legs follow A, giving 4'b0011 for A=1 and 4'b1100 for A=0, and bad_code_o stays 0.
- R5: hiz_n_i low turns every switch off from the next clock edge on, whatever the PWM inputs are.
- R6: pwr_up_i low turns every switch off from the next clock edge on.
- R7: kill_i high turns every switch off from the next clock edge on, even when hiz_n_i and pwr_up_i are high.
- R8: A switch turns off at the first edge after its leg is asked to change. The opposite switch of the same leg turns on only after the leg has been fully off for DT_CYC clock cycles (default 3). The same rule applies to the first turn-on after reset or after a disable is released.
- R9: Every on-period that ends by a change of request lasts at least MINW_CYC cycles (default 4). A request that flips for a single cycle still produces a full MINW_CYC-cycle pulse on the switch it calls for.
- R10: During reset every switch is off and bad_code_o is 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| pwm_a_i | input | NCH | PWM input A, one bit per channel |
| pwm_b_i | input | NCH | PWM input B, one bit per channel |
| par_mode_i | input | 1 | Parallel mode: leg B follows input A |
| hiz_n_i | input | 1 | High-impedance request, active low |
| pwr_up_i | input | 1 | Power-down when low |
| kill_i | input | 1 | Protection kill, highest priority |
| sw_o | output | 4*NCH | Switch enables {Q4,Q3,Q2,Q1} per channel |
| bad_code_o | output | NCH | Unused-code flag per channel |

## Verification
The decode is tried with every input pair on both channels, with the two channels given different codes in the same vector so that swapped channels or swapped legs show up. The same pairs are then repeated in parallel mode, where a design that still listens to B gives a different nibble. The unused code is applied to one channel and then to both, which separates a per-channel flag from a shared one. Directed sequences check the following:
- a single slow transition, which measures the exact dead-time edge counts;
- a one-cycle glitch, which tells stretching apart from dropping;
- each disable input in turn, to show that each one alone clears the outputs at the next edge.

// File: rtl/hb_pkg.sv
package hb_pkg;

    // Per-leg switching state.
    typedef enum logic [2:0] {
        LG_IDLE    = 3'd0,  // both off after reset or disable
        LG_DEAD_HI = 3'd1,  // both off, committed to high side next
        LG_DEAD_LO = 3'd2,  // both off, committed to low side next
        LG_HI      = 3'd3,  // high side conducting
        LG_LO      = 3'd4   // low side conducting
    } leg_st_e;

    // Position of each switch inside a channel nibble.
    localparam int unsigned SW_Q1 = 0;  // leg A high
    localparam int unsigned SW_Q2 = 1;  // leg B high
    localparam int unsigned SW_Q3 = 2;  // leg A low
    localparam int unsigned SW_Q4 = 3;  // leg B low
    localparam int unsigned SW_PER_CH = 4;

endpackage

// File: rtl/hb_decode.sv
module hb_decode (
    input  logic par_i,
    input  logic a_i,
    input  logic b_i,
    output logic req_a_o,
    output logic req_b_o,
    output logic bad_o
);
    // A leg's high side follows its input bit; parallel mode ties leg B to A.
    always_comb begin
        req_a_o = a_i;
        req_b_o = par_i ? a_i : b_i;
        bad_o   = !par_i && a_i && b_i;
    end
endmodule

// File: rtl/hb_leg.sv
module hb_leg
    import hb_pkg::*;
#(
    parameter int unsigned DT_CYC   = 3,
    parameter int unsigned MINW_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic en_i,
    input  logic req_i,   // 1: high side wanted, 0: low side wanted
    output logic hi_o,
    output logic lo_o
);
    localparam int unsigned MAXC = (DT_CYC > MINW_CYC) ? DT_CYC : MINW_CYC;
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] DT_LAST   = CW'(DT_CYC - 1);
    localparam logic [CW-1:0] MINW_LAST = CW'(MINW_CYC - 1);
    localparam logic [CW-1:0] MINW_C    = CW'(MINW_CYC);

    typedef struct packed {
        leg_st_e         st;
        logic [CW-1:0]   cnt;
    } leg_regs_t;

    leg_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!en_i) begin
            r_d.st  = LG_IDLE;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                LG_IDLE: begin
                    if (r_q.cnt >= DT_LAST) begin
                        r_d.st  = req_i ? LG_HI : LG_LO;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                LG_DEAD_HI, LG_DEAD_LO: begin
                    if (r_q.cnt >= DT_LAST) begin
                        r_d.st  = (r_q.st == LG_DEAD_HI) ? LG_HI : LG_LO;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                LG_HI: begin
                    if (!req_i && r_q.cnt >= MINW_LAST) begin
                        r_d.st  = LG_DEAD_LO;
                        r_d.cnt = '0;
                    end else if (r_q.cnt < MINW_LAST) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                LG_LO: begin
                    if (req_i && r_q.cnt >= MINW_LAST) begin
                        r_d.st  = LG_DEAD_HI;
                        r_d.cnt = '0;
                    end else if (r_q.cnt < MINW_LAST) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                default: begin
                    r_d.st  = LG_IDLE;
                    r_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            r_q.st  <= LG_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hi_o = (r_q.st == LG_HI);
    assign lo_o = (r_q.st == LG_LO);

    // Run-length counters of each output, kept for the width checks only.
    logic [CW-1:0] hrun_q, lrun_q;
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            hrun_q <= '0;
            lrun_q <= '0;
        end else begin
            hrun_q <= hi_o ? ((hrun_q == MINW_C) ? hrun_q : hrun_q + 1'b1) : '0;
            lrun_q <= lo_o ? ((lrun_q == MINW_C) ? lrun_q : lrun_q + 1'b1) : '0;
        end
    end

    initial begin
        a_r8_dt_nonzero: assert (DT_CYC >= 1 && MINW_CYC >= 1);
    end

    // R8: a switch never turns on in the cycle right after its partner conducted
    a_r8_hi_after_gap: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(hi_o) |-> !$past(lo_o));
    a_r8_lo_after_gap: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(lo_o) |-> !$past(hi_o));
    // R9: an on-period ended while enabled lasted at least MINW_CYC cycles
    a_r9_hi_min_width: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($fell(hi_o) && $past(en_i)) |-> (hrun_q >= MINW_C));
    a_r9_lo_min_width: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($fell(lo_o) && $past(en_i)) |-> (lrun_q >= MINW_C));
endmodule

// File: rtl/hb_switch_dec.sv
module hb_switch_dec
    import hb_pkg::*;
#(
    parameter int unsigned NCH      = 2,
    parameter int unsigned DT_CYC   = 3,
    parameter int unsigned MINW_CYC = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_n_i,
    input  logic [NCH-1:0]           pwm_a_i,
    input  logic [NCH-1:0]           pwm_b_i,
    input  logic                     par_mode_i,
    input  logic                     hiz_n_i,
    input  logic                     pwr_up_i,
    input  logic                     kill_i,
    output logic [SW_PER_CH*NCH-1:0] sw_o,
    output logic [NCH-1:0]           bad_code_o
);
    typedef struct packed {
        logic [NCH-1:0] bad;
    } top_regs_t;

    top_regs_t      r_d, r_q;
    logic           en;
    logic [NCH-1:0] req_a, req_b, bad_now;

    // Kill has priority; any one disable clears every leg at the next edge.
    assign en = !kill_i && hiz_n_i && pwr_up_i;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        hb_decode u_dec (
            .par_i   (par_mode_i),
            .a_i     (pwm_a_i[c]),
            .b_i     (pwm_b_i[c]),
            .req_a_o (req_a[c]),
            .req_b_o (req_b[c]),
            .bad_o   (bad_now[c])
        );

        hb_leg #(.DT_CYC(DT_CYC), .MINW_CYC(MINW_CYC)) u_leg_a (
            .clk_i   (clk_i),
            .rst_n_i (rst_n_i),
            .en_i    (en),
            .req_i   (req_a[c]),
            .hi_o    (sw_o[SW_PER_CH*c + SW_Q1]),
            .lo_o    (sw_o[SW_PER_CH*c + SW_Q3])
        );

        hb_leg #(.DT_CYC(DT_CYC), .MINW_CYC(MINW_CYC)) u_leg_b (
            .clk_i   (clk_i),
            .rst_n_i (rst_n_i),
            .en_i    (en),
            .req_i   (req_b[c]),
            .hi_o    (sw_o[SW_PER_CH*c + SW_Q2]),
            .lo_o    (sw_o[SW_PER_CH*c + SW_Q4])
        );

        // R3: unused code raises the channel flag one edge later
        a_r3_flag_raise: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (!par_mode_i && pwm_a_i[c] && pwm_b_i[c]) |=> bad_code_o[c]);
        // R4: parallel mode never flags
        a_r4_par_no_flag: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            par_mode_i |=> !bad_code_o[c]);
    end

    always_comb begin
        r_d     = r_q;
        r_d.bad = bad_now;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            r_q.bad <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bad_code_o = r_q.bad;

    a_r5_hiz_off: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !hiz_n_i |=> (sw_o == '0));
    a_r6_pwrdn_off: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !pwr_up_i |=> (sw_o == '0));
    a_r7_kill_off: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        kill_i |=> (sw_o == '0));
endmodule

// File: tb/hb_switch_dec_tb_top.sv
module hb_switch_dec_tb_top;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pwm_a = '0, pwm_b = '0;
    logic           par = 1'b0, hiz_n = 1'b1, pwr_up = 1'b1, kill = 1'b0;
    logic [4*NCH-1:0] sw;
    logic [NCH-1:0] bad;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;  // 50 MHz

    hb_switch_dec #(.NCH(NCH), .DT_CYC(3), .MINW_CYC(4)) dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .pwm_a_i(pwm_a), .pwm_b_i(pwm_b),
        .par_mode_i(par), .hiz_n_i(hiz_n), .pwr_up_i(pwr_up), .kill_i(kill),
        .sw_o(sw), .bad_code_o(bad)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Vector: {par, a[1:0], b[1:0], exp_sw[7:0], exp_bad[1:0]}
    localparam logic [14:0] VEC [9] = '{
        {1'b0, 2'b00, 2'b00, 8'hCC, 2'b00},  // R1 damp on both channels
        {1'b0, 2'b01, 2'b10, 8'h69, 2'b00},  // R2 ch0 positive, ch1 negative
        {1'b0, 2'b10, 2'b01, 8'h96, 2'b00},  // R2 swapped
        {1'b0, 2'b11, 2'b00, 8'h99, 2'b00},  // R2 both positive
        {1'b0, 2'b01, 2'b01, 8'hC3, 2'b01},  // R3 ch0 unused code
        {1'b0, 2'b11, 2'b11, 8'h33, 2'b11},  // R3 both unused
        {1'b1, 2'b01, 2'b10, 8'hC3, 2'b00},  // R4 B ignored
        {1'b1, 2'b10, 2'b01, 8'h3C, 2'b00},  // R4 B ignored
        {1'b1, 2'b11, 2'b11, 8'h33, 2'b00}   // R4 no flag
    };

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        step(3);
        chk("R10 sw in reset", sw, 8'h00);
        chk("R10 flag in reset", {6'b0, bad}, 8'h00);
        rst_n = 1'b1;
        step(2);
        chk("R8 still dead after reset", sw, 8'h00);
        step(1);
        chk("R8 on after DT from reset", sw, 8'hCC);

        for (int i = 0; i < 9; i++) begin
            par   = VEC[i][14];
            pwm_a = VEC[i][13:12];
            pwm_b = VEC[i][11:10];
            step(14);
            chk($sformatf("R1/R2/R3/R4 vector %0d sw", i), sw, VEC[i][9:2]);
            chk($sformatf("R3/R4 vector %0d flag", i), {6'b0, bad}, {6'b0, VEC[i][1:0]});
        end

        // R8: dead time on channel 0 leg A, from low side to high side
        par = 1'b0; pwm_a = 2'b00; pwm_b = 2'b00;
        step(20);
        pwm_a = 2'b01;
        step(1);
        chk("R8 turn-off immediate", {6'b0, sw[2], sw[0]}, 8'h00);
        step(2);
        chk("R8 still dead", {7'b0, sw[0]}, 8'h00);
        step(1);
        chk("R8 Q1 on after DT", {6'b0, sw[2], sw[0]}, 8'h01);
        chk("R8 leg B untouched", {7'b0, sw[3]}, 8'h01);

        // R9: one-cycle low glitch is stretched
        step(10);
        pwm_a = 2'b00;
        step(1);
        chk("R9 Q1 off at glitch", {7'b0, sw[0]}, 8'h00);
        pwm_a = 2'b01;
        step(3);
        chk("R9 Q3 pulse appears", {7'b0, sw[2]}, 8'h01);
        step(3);
        chk("R9 Q3 held to min width", {7'b0, sw[2]}, 8'h01);
        step(1);
        chk("R9 Q3 released after min width", {7'b0, sw[2]}, 8'h00);
        step(3);
        chk("R9 Q1 back after dead time", {7'b0, sw[0]}, 8'h01);

        // R7: kill overrides while other enables are active
        pwm_a = 2'b10; pwm_b = 2'b01;
        step(14);
        kill = 1'b1;
        step(1);
        chk("R7 kill clears", sw, 8'h00);
        pwm_a = 2'b01; pwm_b = 2'b10;
        step(3);
        chk("R7 kill holds", sw, 8'h00);
        kill = 1'b0;
        step(2);
        chk("R8 dead after kill release", sw, 8'h00);
        step(1);
        chk("R8 on after kill release", sw, 8'h69);

        // R5: high-impedance request
        hiz_n = 1'b0;
        step(1);
        chk("R5 hiz clears", sw, 8'h00);
        hiz_n = 1'b1;
        step(10);
        chk("R5 resumes", sw, 8'h69);

        // R6: power-down
        pwr_up = 1'b0;
        step(1);
        chk("R6 power-down clears", sw, 8'h00);
        pwr_up = 1'b1;
        step(10);
        chk("R6 resumes", sw, 8'h69);

        // R3: flag follows the code one edge later
        pwm_a = 2'b10; pwm_b = 2'b10;
        step(1);
        chk("R3 flag ch1 only", {6'b0, bad}, 8'h02);
        par = 1'b1;
        step(1);
        chk("R4 flag cleared by parallel", {6'b0, bad}, 8'h00);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule